// File: doc/BRIEF.md
# Compare-Match ADC Trigger Controller

This block paces analog-to-digital conversions from a free-running time base. It has two independent 16-bit up-counters. One of them is picked as the time base and compared every cycle against a 16-bit compare value. When the compare mode field holds the special-trigger code and the picked counter equals the compare value, the block emits a one-cycle trigger pulse. The same match restarts the picked counter from zero, so the sampling interval repeats with no software action.

If the converter is enabled, the trigger also sets a start/busy flag. A small sequencer then models a conversion of fixed length. At the end it clears the flag, raises a completion interrupt flag and latches a 10-bit sample from an input port into a pair of result registers. Software reaches all state through a synchronous byte-wide write/read port. A read returns its data one cycle after the request.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After `rst_por`, the control register reads 0x00, the completion flag, `adc_trig_o`, `conv_busy_o` and `done_irq_o` are 0, and the mode register (address 1) reads 0x00.
- R2: The control register (address 0) holds clock select in bits 7:6 and channel in bits 5:3, driven onto `clk_sel_o` and `chan_sel_o`. Bit 2 reads the busy state, bit 1 always reads 0, and bit 0 is the converter enable.
- R3: A trigger is produced only while mode register bits 3:0 equal 4'b1011. With any other code, no trigger pulse occurs and the counters keep running.
- R4: The compare value is at addresses 2 (low byte) and 3 (high byte). When the picked counter equals it, on the next clock that counter reads 0 instead of incrementing and `adc_trig_o` is high for that one cycle, giving a period of compare+1 cycles.
- R5: Mode register bit 4 picks the time base (0: counter A at addresses 8/9, 1: counter B at addresses 10/11, low byte first). A trigger resets only the picked counter; the other one keeps counting.
- R6: A trigger with the enable bit set starts a conversion in the same cycle the trigger pulse is seen. With the enable bit clear, no conversion starts, but the counter is still reset.
- R7: A conversion keeps `conv_busy_o` high for exactly CONV_CYCLES (12) cycles. At its end, busy clears and the completion flag sets on the same clock edge. The sample is stored right-justified: address 4 reads {6'b0, sample[9:8]} and address 5 reads sample[7:0].
- R8: While a conversion is running, further start requests (triggers or software writes) are ignored and do not lengthen it.
- R9: Writing the control register with bits 2 and 0 both set starts a conversion; with bit 0 clear, no conversion starts. Writing 0 to bit 2 does not end a running conversion. Writing 0 to bit 0 of the flag register (address 6) clears the completion flag.
- R10: `rst_sys` clears all state except the two result registers, which keep their values. `rst_por` clears the result registers as well.
- R11: A read request (`rd_en`) returns `rd_data` with `rd_valid` high in the following cycle only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high, clears everything |
| rst_sys | input | 1 | Other reset, synchronous, active high, result registers kept |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| sample_i | input | SMP_W | Converter sample latched at end of conversion |
| adc_trig_o | output | 1 | One-cycle compare-match trigger |
| conv_busy_o | output | 1 | Conversion in progress |
| done_irq_o | output | 1 | Completion interrupt flag |
| chan_sel_o | output | 3 | Channel select field |
| clk_sel_o | output | 2 | Converter clock select field |

## Verification
The bench measures the trigger period exactly at two compare values. A design that kept incrementing past the match, or cleared the counter one cycle late, would show a period off by one. It reads the unselected counter before and after a trigger of the other one, which catches a design that resets both time bases. It counts busy cycles while a second software start is issued in mid-conversion, and checks that a disabled trigger still restarts the period. This exposes designs that restart the conversion, or that tie the counter reset to the enable bit. Finally it checks that the result bytes survive the non-power-on reset and are cleared by the power-on one; a design that cleared or kept both on every reset would fail here.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  localparam int REG_W = 8;
  localparam int ADR_W = 4;

  localparam logic [3:0] MODE_SPECIAL = 4'b1011;

  localparam logic [ADR_W-1:0] ADDR_CTRL    = 4'd0;
  localparam logic [ADR_W-1:0] ADDR_MODE    = 4'd1;
  localparam logic [ADR_W-1:0] ADDR_CMP_LO  = 4'd2;
  localparam logic [ADR_W-1:0] ADDR_CMP_HI  = 4'd3;
  localparam logic [ADR_W-1:0] ADDR_RES_HI  = 4'd4;
  localparam logic [ADR_W-1:0] ADDR_RES_LO  = 4'd5;
  localparam logic [ADR_W-1:0] ADDR_FLAG    = 4'd6;
  localparam logic [ADR_W-1:0] ADDR_TB_BASE = 4'd8;

  // control register layout, bit 7 down to bit 0
  typedef struct packed {
    logic [1:0] clk_sel;
    logic [2:0] chan;
    logic       go;
    logic       rsvd;
    logic       en;
  } ctrl_t;

endpackage

// File: rtl/atc_timebase.sv
module atc_timebase #(
  parameter int CNT_W = 16,
  parameter int N_TB  = 2,
  localparam int SEL_W = (N_TB > 1) ? $clog2(N_TB) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr_en,
  input  logic [SEL_W-1:0]        clr_idx,
  output logic [N_TB*CNT_W-1:0]   cnt_o
);

  generate
    for (genvar g = 0; g < N_TB; g++) begin : g_tb
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (clr_en && (clr_idx == SEL_W'(g))) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      assign cnt_o[g*CNT_W +: CNT_W] = cnt_q;
    end
  endgenerate

endmodule

// File: rtl/atc_compare.sv
module atc_compare #(
  parameter int CNT_W = 16,
  parameter int N_TB  = 2,
  localparam int SEL_W = (N_TB > 1) ? $clog2(N_TB) : 1
) (
  input  logic [N_TB*CNT_W-1:0] cnt_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [CNT_W-1:0]      cmp_i,
  input  logic [3:0]            mode_i,
  output logic                  match_o
);
  import adc_trig_pkg::*;

  logic [CNT_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int g = 0; g < N_TB; g++) begin
      if (sel_i == SEL_W'(g)) picked = cnt_i[g*CNT_W +: CNT_W];
    end
  end

  assign match_o = (mode_i == MODE_SPECIAL) && (picked == cmp_i);

endmodule

// File: rtl/atc_sequencer.sv
module atc_sequencer #(
  parameter int SMP_W       = 10,
  parameter int CONV_CYCLES = 12,
  parameter int REG_W       = 8,
  localparam int CW         = $clog2(CONV_CYCLES),
  localparam int RES_W      = 2 * REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_por,
  input  logic             start_i,
  input  logic [SMP_W-1:0] sample_i,
  output logic             busy_o,
  output logic             end_o,
  output logic [REG_W-1:0] res_hi_o,
  output logic [REG_W-1:0] res_lo_o
);

  logic          busy_q;
  logic [CW-1:0] left_q;
  logic [RES_W-1:0] res_q;

  assign end_o = busy_q && (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        left_q <= CW'(CONV_CYCLES - 1);
      end
    end else if (left_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      left_q <= left_q - 1'b1;
    end
  end

  // result survives the non-power-on reset
  always_ff @(posedge clk) begin
    if (rst_por) begin
      res_q <= '0;
    end else if (end_o) begin
      res_q <= RES_W'(sample_i);
    end
  end

  assign busy_o   = busy_q;
  assign res_hi_o = res_q[RES_W-1:REG_W];
  assign res_lo_o = res_q[REG_W-1:0];

endmodule

// File: rtl/atc_regs.sv
module atc_regs #(
  parameter int CNT_W = 16,
  parameter int N_TB  = 2,
  localparam int SEL_W = (N_TB > 1) ? $clog2(N_TB) : 1,
  localparam int REG_W = adc_trig_pkg::REG_W,
  localparam int ADR_W = adc_trig_pkg::ADR_W,
  localparam int EXT_W = 2 * REG_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADR_W-1:0]      addr,
  input  logic [REG_W-1:0]      wdata,
  input  logic                  busy_i,
  input  logic                  conv_end_i,
  input  logic [REG_W-1:0]      res_hi_i,
  input  logic [REG_W-1:0]      res_lo_i,
  input  logic [N_TB*CNT_W-1:0] cnt_i,
  output logic                  en_o,
  output logic [2:0]            chan_o,
  output logic [1:0]            clk_sel_o,
  output logic [3:0]            mode_o,
  output logic [SEL_W-1:0]      sel_o,
  output logic [CNT_W-1:0]      cmp_o,
  output logic                  flag_o,
  output logic                  sw_go_o,
  output logic [REG_W-1:0]      rd_data_o,
  output logic                  rd_valid_o
);
  import adc_trig_pkg::*;

  ctrl_t            wr_ctrl;
  logic             en_q;
  logic [2:0]       chan_q;
  logic [1:0]       clk_sel_q;
  logic [3:0]       mode_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cmp_q;
  logic             flag_q;
  logic [REG_W-1:0] rd_mux;
  logic [REG_W-1:0] rd_q;
  logic             rdv_q;
  logic [EXT_W-1:0] cmp_ext;

  assign wr_ctrl = ctrl_t'(wdata);
  assign sw_go_o = wr_en && (addr == ADDR_CTRL) && wr_ctrl.go && wr_ctrl.en;
  assign cmp_ext = EXT_W'(cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      chan_q    <= '0;
      clk_sel_q <= '0;
      mode_q    <= '0;
      sel_q     <= '0;
      cmp_q     <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_CTRL: begin
          en_q      <= wr_ctrl.en;
          chan_q    <= wr_ctrl.chan;
          clk_sel_q <= wr_ctrl.clk_sel;
        end
        ADDR_MODE: begin
          mode_q <= wdata[3:0];
          sel_q  <= wdata[4 +: SEL_W];
        end
        ADDR_CMP_LO: cmp_q[REG_W-1:0] <= wdata;
        ADDR_CMP_HI: cmp_q[CNT_W-1:REG_W] <= wdata[CNT_W-REG_W-1:0];
        default: ;
      endcase
    end
  end

  // completion wins over a software clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (conv_end_i) begin
      flag_q <= 1'b1;
    end else if (wr_en && (addr == ADDR_FLAG) && !wdata[0]) begin
      flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_CTRL:   rd_mux = {clk_sel_q, chan_q, busy_i, 1'b0, en_q};
      ADDR_MODE: begin
        rd_mux[3:0]       = mode_q;
        rd_mux[4 +: SEL_W] = sel_q;
      end
      ADDR_CMP_LO: rd_mux = cmp_ext[REG_W-1:0];
      ADDR_CMP_HI: rd_mux = cmp_ext[EXT_W-1:REG_W];
      ADDR_RES_HI: rd_mux = res_hi_i;
      ADDR_RES_LO: rd_mux = res_lo_i;
      ADDR_FLAG:   rd_mux = {{(REG_W-1){1'b0}}, flag_q};
      default: begin
        for (int g = 0; g < N_TB; g++) begin
          if (addr == ADR_W'(ADDR_TB_BASE + 2*g))
            rd_mux = REG_W'(cnt_i[g*CNT_W +: REG_W]);
          else if (addr == ADR_W'(ADDR_TB_BASE + 2*g + 1))
            rd_mux = REG_W'(cnt_i[g*CNT_W + REG_W +: (CNT_W-REG_W)]);
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      rdv_q <= 1'b0;
    end else begin
      rdv_q <= rd_en;
      if (rd_en) rd_q <= rd_mux;
    end
  end

  assign en_o       = en_q;
  assign chan_o     = chan_q;
  assign clk_sel_o  = clk_sel_q;
  assign mode_o     = mode_q;
  assign sel_o      = sel_q;
  assign cmp_o      = cmp_q;
  assign flag_o     = flag_q;
  assign rd_data_o  = rd_q;
  assign rd_valid_o = rdv_q;

endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl #(
  parameter int CNT_W       = 16,
  parameter int N_TB        = 2,
  parameter int SMP_W       = 10,
  parameter int CONV_CYCLES = 12,
  localparam int SEL_W      = (N_TB > 1) ? $clog2(N_TB) : 1,
  localparam int REG_W      = adc_trig_pkg::REG_W,
  localparam int ADR_W      = adc_trig_pkg::ADR_W
) (
  input  logic             clk,
  input  logic             rst_por,
  input  logic             rst_sys,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [ADR_W-1:0] addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rd_data,
  output logic             rd_valid,
  input  logic [SMP_W-1:0] sample_i,
  output logic             adc_trig_o,
  output logic             conv_busy_o,
  output logic             done_irq_o,
  output logic [2:0]       chan_sel_o,
  output logic [1:0]       clk_sel_o
);

  logic                  rst_any;
  logic [N_TB*CNT_W-1:0] cnt_flat;
  logic [SEL_W-1:0]      tb_sel;
  logic [CNT_W-1:0]      cmp;
  logic [3:0]            mode;
  logic                  match;
  logic                  en;
  logic                  sw_go;
  logic                  busy;
  logic                  conv_end;
  logic                  start;
  logic                  trig_q;
  logic                  flag;
  logic [REG_W-1:0]      res_hi;
  logic [REG_W-1:0]      res_lo;

  assign rst_any = rst_por | rst_sys;

  atc_timebase #(.CNT_W(CNT_W), .N_TB(N_TB)) u_tb (
    .clk     (clk),
    .rst     (rst_any),
    .clr_en  (match),
    .clr_idx (tb_sel),
    .cnt_o   (cnt_flat)
  );

  atc_compare #(.CNT_W(CNT_W), .N_TB(N_TB)) u_cmp (
    .cnt_i   (cnt_flat),
    .sel_i   (tb_sel),
    .cmp_i   (cmp),
    .mode_i  (mode),
    .match_o (match)
  );

  assign start = (match && en) || sw_go;

  atc_sequencer #(.SMP_W(SMP_W), .CONV_CYCLES(CONV_CYCLES), .REG_W(REG_W)) u_seq (
    .clk      (clk),
    .rst      (rst_any),
    .rst_por  (rst_por),
    .start_i  (start),
    .sample_i (sample_i),
    .busy_o   (busy),
    .end_o    (conv_end),
    .res_hi_o (res_hi),
    .res_lo_o (res_lo)
  );

  atc_regs #(.CNT_W(CNT_W), .N_TB(N_TB)) u_regs (
    .clk        (clk),
    .rst        (rst_any),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .busy_i     (busy),
    .conv_end_i (conv_end),
    .res_hi_i   (res_hi),
    .res_lo_i   (res_lo),
    .cnt_i      (cnt_flat),
    .en_o       (en),
    .chan_o     (chan_sel_o),
    .clk_sel_o  (clk_sel_o),
    .mode_o     (mode),
    .sel_o      (tb_sel),
    .cmp_o      (cmp),
    .flag_o     (flag),
    .sw_go_o    (sw_go),
    .rd_data_o  (rd_data),
    .rd_valid_o (rd_valid)
  );

  always_ff @(posedge clk) begin
    if (rst_any) trig_q <= 1'b0;
    else         trig_q <= match;
  end

  assign adc_trig_o  = trig_q;
  assign conv_busy_o = busy;
  assign done_irq_o  = flag;

endmodule

// File: rtl/atc_checker.sv
module atc_checker #(
  parameter int CNT_W       = 16,
  parameter int N_TB        = 2,
  parameter int CONV_CYCLES = 12,
  localparam int SEL_W      = (N_TB > 1) ? $clog2(N_TB) : 1,
  localparam int RUN_W      = $clog2(CONV_CYCLES + 1) + 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  trig,
  input logic                  busy,
  input logic                  flag,
  input logic                  match,
  input logic                  en,
  input logic                  sw_go,
  input logic [3:0]            mode,
  input logic [SEL_W-1:0]      tb_sel,
  input logic [N_TB*CNT_W-1:0] cnt_flat,
  input logic                  rd_en,
  input logic                  rd_valid,
  input logic [3:0]            addr,
  input logic [7:0]            rd_data
);
  import adc_trig_pkg::*;

  logic [SEL_W-1:0]      sel_d;
  logic [N_TB*CNT_W-1:0] cnt_d;
  logic [3:0]            addr_d;
  logic [RUN_W-1:0]      run;
  logic [CNT_W-1:0]      sel_now;

  always_ff @(posedge clk) begin
    sel_d <= tb_sel;
    cnt_d <= cnt_flat;
    if (rd_en) addr_d <= addr;
    if (rst)       run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  assign sel_now = cnt_flat[int'(sel_d)*CNT_W +: CNT_W];

  AST_TRIG_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
    trig |-> $past(mode == MODE_SPECIAL)); // R3

  AST_TRIG_RESTARTS_BASE: assert property (@(posedge clk) disable iff (rst)
    trig |-> (sel_now == '0)); // R4

  generate
    if (N_TB == 2) begin : g_pair
      logic [CNT_W-1:0] oth_now;
      logic [CNT_W-1:0] oth_was;
      assign oth_now = cnt_flat[int'(~sel_d)*CNT_W +: CNT_W];
      assign oth_was = cnt_d[int'(~sel_d)*CNT_W +: CNT_W];
      AST_OTHER_BASE_RUNS: assert property (@(posedge clk) disable iff (rst)
        trig |-> (oth_now == oth_was + 1'b1)); // R5
    end
  endgenerate

  AST_START_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past((match && en) || sw_go)); // R6

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run == RUN_W'(CONV_CYCLES))); // R8

  AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> flag); // R7

  AST_GO_BIT_IS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && addr_d == ADDR_CTRL) |-> (rd_data[2] == $past(busy) && !rd_data[1])); // R2

endmodule

bind adc_trig_ctrl atc_checker #(
  .CNT_W(CNT_W), .N_TB(N_TB), .CONV_CYCLES(CONV_CYCLES)
) u_chk (
  .clk      (clk),
  .rst      (rst_any),
  .trig     (adc_trig_o),
  .busy     (conv_busy_o),
  .flag     (done_irq_o),
  .match    (match),
  .en       (en),
  .sw_go    (sw_go),
  .mode     (mode),
  .tb_sel   (tb_sel),
  .cnt_flat (cnt_flat),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .addr     (addr),
  .rd_data  (rd_data)
);

// File: tb/test_adc_trig_ctrl.sv
`timescale 1ns/1ps
module test_adc_trig_ctrl;

  logic       clk = 1'b0;
  logic       rst_por = 1'b1;
  logic       rst_sys = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic [9:0] sample_i = '0;
  logic       adc_trig_o;
  logic       conv_busy_o;
  logic       done_irq_o;
  logic [2:0] chan_sel_o;
  logic [1:0] clk_sel_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  logic [7:0] msk_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  adc_trig_ctrl i_adc_trig_ctrl (
    .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .sample_i(sample_i),
    .adc_trig_o(adc_trig_o), .conv_busy_o(conv_busy_o),
    .done_irq_o(done_irq_o), .chan_sel_o(chan_sel_o), .clk_sel_o(clk_sel_o)
  );

  task automatic check(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: push the expected byte, the monitor compares it
  task automatic rd(logic [3:0] a, logic [7:0] e, string tag);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); msk_q.push_back(8'hFF); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_raw(logic [3:0] a, output logic [7:0] v);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(8'h00); msk_q.push_back(8'h00); tag_q.push_back("raw");
    @(negedge clk);
    v = rd_data;
    rd_en = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rd_valid && !finished) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected read data", int'(rd_data), 0);
      end else begin
        logic [7:0] e, m;
        string t;
        e = exp_q.pop_front(); m = msk_q.pop_front(); t = tag_q.pop_front();
        if (m != 8'h00) check((rd_data & m) == (e & m), t, int'(rd_data), int'(e));
      end
    end
  end

  task automatic wait_trig(int lim, output bit seen);
    int n = 0;
    while (!adc_trig_o && n < lim) begin
      @(negedge clk); n++;
    end
    seen = adc_trig_o;
  endtask

  // starts on a trigger cycle, returns on the next one
  task automatic period(output int n, output bit saw_busy);
    n = 0; saw_busy = 1'b0;
    do begin
      @(negedge clk); n++;
      if (conv_busy_o) saw_busy = 1'b1;
    end while (!adc_trig_o && n < 70000);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    bit seen, sb;
    int n, trigs;
    logic [7:0] a1, a2;

    step(3);
    rst_por = 1'b0;
    check(!adc_trig_o && !conv_busy_o && !done_irq_o, "R1 outputs after reset",
          {adc_trig_o, conv_busy_o, done_irq_o}, 0);
    rd(4'd0, 8'h00, "R1 control after reset");
    check(rd_valid == 1'b1, "R11 valid one cycle after request", rd_valid, 1);
    step(1);
    check(rd_valid == 1'b0, "R11 valid lasts one cycle", rd_valid, 0);
    rd(4'd6, 8'h00, "R1 flag after reset");
    rd(4'd1, 8'h00, "R1 mode after reset");
    rd(4'd4, 8'h00, "R10 result high after power-on reset");
    rd(4'd5, 8'h00, "R10 result low after power-on reset");

    // periodic trigger on counter A, converter disabled
    wr(4'd2, 8'd200);
    wr(4'd3, 8'd0);
    wr(4'd1, 8'h0B);
    wait_trig(70000, seen);
    check(seen, "R4 first trigger on counter A", seen, 1);
    period(n, sb);
    check(n == 201, "R4 period with compare 200", n, 201);
    check(!sb, "R6 disabled converter stays idle", sb, 0);
    wr(4'd2, 8'd3);
    wait_trig(10, seen);
    period(n, sb);
    check(n == 4, "R4 period with compare 3", n, 4);
    rd(4'd8, 8'h00, "R4 counter reads zero in trigger cycle");
    check(!adc_trig_o, "R4 trigger lasts one cycle", adc_trig_o, 0);

    // other mode codes give no trigger
    wait_trig(10, seen);
    wr(4'd1, 8'h0A);
    trigs = 0;
    for (int i = 0; i < 40; i++) begin
      step(1);
      if (adc_trig_o) trigs++;
    end
    check(trigs == 0, "R3 no trigger with mode 1010", trigs, 0);

    // counter B as time base
    wr(4'd2, 8'd40);
    wr(4'd1, 8'h1B);
    wait_trig(70000, seen);
    check(seen, "R5 trigger on counter B", seen, 1);
    period(n, sb);
    check(n == 41, "R5 period on counter B", n, 41);
    rd_raw(4'd8, a1);
    step(45);
    rd_raw(4'd8, a2);
    check(a2 == 8'(a1 + 8'd46), "R5 counter A not reset by B trigger", a2, 8'(a1 + 8'd46));

    // trigger-started conversion
    sample_i = 10'h2A5;
    wait_trig(50, seen);
    wr(4'd0, 8'h01);
    n = 0;
    while (!conv_busy_o && n < 60) begin step(1); n++; end
    check(adc_trig_o && conv_busy_o, "R6 conversion starts with trigger",
          {adc_trig_o, conv_busy_o}, 3);
    n = 0;
    while (conv_busy_o && n < 40) begin n++; step(1); end
    check(n == 12, "R7 busy length", n, 12);
    check(done_irq_o, "R7 flag set at end", done_irq_o, 1);
    wr(4'd0, 8'h08);
    rd(4'd0, 8'h08, "R2 control readback channel 1");
    check(chan_sel_o == 3'd1 && clk_sel_o == 2'd0, "R2 field outputs",
          {clk_sel_o, chan_sel_o}, 1);
    rd(4'd4, 8'h02, "R7 result high byte");
    rd(4'd5, 8'hA5, "R7 result low byte");
    rd(4'd6, 8'h01, "R7 flag register");
    wr(4'd6, 8'h00);
    rd(4'd6, 8'h00, "R9 flag cleared by write");
    check(!done_irq_o, "R9 interrupt cleared", done_irq_o, 0);
    wr(4'd0, 8'hCA);
    rd(4'd0, 8'hC8, "R2 bit 1 reads zero, clock select");
    check(clk_sel_o == 2'd3, "R2 clock select output", clk_sel_o, 3);

    // disabled converter: timer still restarted
    wait_trig(60, seen);
    period(n, sb);
    check(n == 41, "R6 period kept while disabled", n, 41);
    check(!sb, "R6 no conversion while disabled", sb, 0);

    // software start
    wr(4'd1, 8'h1A);
    sample_i = 10'h15A;
    wr(4'd0, 8'h04);
    check(!conv_busy_o, "R9 go without enable ignored", conv_busy_o, 0);
    wr(4'd0, 8'h05);
    check(conv_busy_o, "R9 software start", conv_busy_o, 1);
    n = 0;
    while (conv_busy_o && n < 40) begin
      n++;
      if (n == 4) begin wr_en = 1'b1; addr = 4'd0; wdata = 8'h05; end
      else if (n == 6) begin wr_en = 1'b1; addr = 4'd0; wdata = 8'h01; end
      else wr_en = 1'b0;
      if (n == 8) check(conv_busy_o, "R9 go write of 0 keeps busy", conv_busy_o, 1);
      step(1);
    end
    wr_en = 1'b0;
    check(n == 12, "R8 second start does not extend", n, 12);
    rd(4'd4, 8'h01, "R7 result high byte second sample");
    rd(4'd5, 8'h5A, "R7 result low byte second sample");

    // resets
    rst_sys = 1'b1; step(2); rst_sys = 1'b0;
    check(!done_irq_o && !conv_busy_o, "R10 system reset clears flags",
          {done_irq_o, conv_busy_o}, 0);
    rd(4'd0, 8'h00, "R10 control cleared by system reset");
    rd(4'd1, 8'h00, "R10 mode cleared by system reset");
    rd(4'd4, 8'h01, "R10 result high kept");
    rd(4'd5, 8'h5A, "R10 result low kept");
    rst_por = 1'b1; step(2); rst_por = 1'b0;
    rd(4'd4, 8'h00, "R10 result high cleared by power-on reset");
    rd(4'd5, 8'h00, "R10 result low cleared by power-on reset");
    step(3);
    check(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 0);
    finish_run();
  end

endmodule